// File: doc/BRIEF.md
# Machine Check Capture Unit

This unit gathers hardware error reports from a processor core and turns them into either a recoverable machine check exception or a terminal checkstop. Error reports arrive on two groups of inputs. The first group carries five on-chip array check results. The second group carries six bus and internal conditions. A machine-check-enable bit inside the 32-bit machine state word picks the outcome. When the bit is set, the unit takes an exception. When it is clear, the unit enters checkstop.

On an exception, the unit records the current instruction address. It builds a saved status word whose bit positions name each cause that fired, and copies the low half of the machine state into it. It then rewrites the machine state for handler entry and pulses a vector-taken output. Handler entry clears the enable bit, so a second fault before software sets that bit again ends in checkstop. Checkstop is sticky, blocks instruction retirement, and leaves only through hard reset.

Software reloads the machine state in one of two ways. A write port loads the whole word. A return-from-interrupt request restores bits 16 to 31 from the saved status. A check-enable input, sampled while hard reset is held, arms the unit to accept one self-test result from an external array test engine. Any failures in that result are reported as array causes.

Top module: `mchk_capture_unit`

## Requirements
- R1: An error input or an accepted self-test failure, seen at a clock edge while state bit 19 (machine-check enable) is 1 and the unit is not in checkstop, raises `vectorTaken` for exactly the following cycle. `checkstop` stays 0.
- R2: An error seen while state bit 19 is 0 sets `checkstop` in the following cycle, with no `vectorTaken` pulse.
- R3: On exception entry, the new state keeps bit 15 (little-endian interrupt mode) and bit 25 (vector prefix). Bit 31 (little-endian mode) is loaded from the old bit 15. Every other bit, including enable bit 19, becomes 0. Bit numbering is big-endian: bit 0 is the MSB.
- R4: In `savedStatus`, `errArray[i]` maps to bit 1+i. The array sources in order are instruction cache, data cache, L2 tag, translation buffer, and branch prediction arrays.
- R5: In `savedStatus`, `errBus[j]` maps to bit 10+j. The sources in order are internal error, L2 data parity, machine-check pin, bus transfer error acknowledge, data bus parity, and address bus parity.
- R6: `savedStatus` bits 0 and 6 to 9, and the cause bits of absent sources, are 0. Bits 16 to 31 equal the state bits 16 to 31 held before entry.
- R7: `savedPc` takes `instAddr` as sampled at the edge of the fault.
- R8: Causes present at the same edge are all recorded together in a single capture.
- R9: If `chkEnable` is high during reset, the next `selfTestDone` pulse injects `selfTestFail[i]` as array cause i and then disarms. When the unit is not armed, `selfTestDone` has no effect.
- R10: `rfiReq` loads state bits 16 to 31 from `savedStatus` bits 16 to 31 and leaves bits 0 to 15 unchanged. An exception in the same cycle takes priority, and the request is dropped.
- R11: `stateWrEn` loads the whole state word. An exception or a return request in the same cycle takes priority over it.
- R12: In checkstop, errors change neither `savedStatus` nor `savedPc`. Only reset clears `checkstop`. Reset sets the state and saved registers to 0.
- R13: `retireGrant` equals `retireReq` while not in checkstop, and is 0 in checkstop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous hard reset, active low |
| chkEnable | input | 1 | Arms the self-test when sampled during reset |
| errArray | input | 5 | Array error reports (see R4) |
| errBus | input | 6 | Bus and internal error reports (see R5) |
| selfTestDone | input | 1 | Self-test engine result strobe |
| selfTestFail | input | 5 | Self-test per-array failure flags |
| instAddr | input | ADDR_W | Address of the current instruction |
| rfiReq | input | 1 | Return-from-interrupt restore request |
| stateWrEn | input | 1 | Software state write enable |
| stateWrData | input | 32 | Software state write value |
| retireReq | input | 1 | Core requests instruction retirement |
| stateWord | output | 32 | Machine state word, bit 0 is the MSB |
| savedPc | output | ADDR_W | Captured instruction address |
| savedStatus | output | 32 | Captured cause syndrome and inherited state |
| vectorTaken | output | 1 | One-cycle exception pulse |
| checkstop | output | 1 | Sticky terminal error flag |
| retireGrant | output | 1 | Retirement permitted |

## Verification
Several behaviours are checked by assertions on every cycle. These are the stickiness of checkstop, the single-cycle shape of the vector pulse and the fact that it never coincides with checkstop. They also cover the clearing of the enable bit on entry, the copy of the interrupt-mode bit into the mode bit, the inherited low half of the saved status, and the holding of the saved registers when no exception is taken. The bench's scenarios are needed for the rest: the exact cause-bit layout for every source, multi-cause capture, and address capture. The same holds for self-test arming and disarming through reset, restore priority against errors and writes, and recovery from checkstop through reset.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int ARR_N      = 5;
  localparam int BUS_N      = 6;
  localparam int POS_ILE    = 15;
  localparam int POS_ME     = 19;
  localparam int POS_IP     = 25;
  localparam int POS_LE     = 31;
  localparam int ARR_BASE   = 1;
  localparam int BUS_BASE   = 10;

  typedef struct packed {
    logic takeExc;
    logic doRfi;
    logic doWrite;
  } mckStrobe_t;
endpackage

// File: rtl/mck_control.sv
module mck_control
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chkEnable,
  input  logic [ARR_N-1:0] errArray,
  input  logic [BUS_N-1:0] errBus,
  input  logic             selfTestDone,
  input  logic [ARR_N-1:0] selfTestFail,
  input  logic             meBit,
  input  logic             rfiReq,
  input  logic             stateWrEn,
  input  logic             retireReq,
  output mckStrobe_t       strobe,
  output logic [ARR_N-1:0] arrayCause,
  output logic             checkstop,
  output logic             vectorTaken,
  output logic             retireGrant
);
  logic testArmed;
  logic anyErr;
  logic enterStop;

  assign arrayCause  = errArray | ((selfTestDone && testArmed) ? selfTestFail : '0);
  assign anyErr      = (|arrayCause) || (|errBus);
  assign enterStop   = !checkstop && anyErr && !meBit;
  assign retireGrant = retireReq && !checkstop;

  always_comb begin
    strobe.takeExc = !checkstop && anyErr && meBit;
    strobe.doRfi   = rfiReq && !strobe.takeExc;
    strobe.doWrite = stateWrEn && !strobe.takeExc && !rfiReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      checkstop   <= 1'b0;
      vectorTaken <= 1'b0;
      testArmed   <= chkEnable;
    end else begin
      checkstop   <= checkstop || enterStop;
      vectorTaken <= strobe.takeExc;
      if (selfTestDone) testArmed <= 1'b0;
    end
  end

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |=> checkstop); // R12
  AST_STOP_ON_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (anyErr && !meBit) |=> checkstop); // R2
  AST_VEC_NOT_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |-> !vectorTaken); // R1
  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    vectorTaken |=> !vectorTaken); // R1
endmodule

// File: rtl/mck_datapath.sv
module mck_datapath
  import mck_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mckStrobe_t        strobe,
  input  logic [ARR_N-1:0]  arrayCause,
  input  logic [BUS_N-1:0]  errBus,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [0:31]       stateWrData,
  output logic [0:31]       stateWord,
  output logic [ADDR_W-1:0] savedPc,
  output logic [0:31]       savedStatus,
  output logic              meBit
);
  logic [0:31] syndrome;
  logic [0:31] entryState;
  logic [0:31] rfiState;

  assign meBit = stateWord[POS_ME];

  always_comb begin
    syndrome = '0;
    for (int i = 0; i < ARR_N; i++) syndrome[ARR_BASE + i] = arrayCause[i];
    for (int j = 0; j < BUS_N; j++) syndrome[BUS_BASE + j] = errBus[j];
    syndrome[16:31] = stateWord[16:31];
  end

  always_comb begin
    entryState          = '0;
    entryState[POS_ILE] = stateWord[POS_ILE];
    entryState[POS_IP]  = stateWord[POS_IP];
    entryState[POS_LE]  = stateWord[POS_ILE];
  end

  assign rfiState = {stateWord[0:15], savedStatus[16:31]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateWord   <= '0;
      savedPc     <= '0;
      savedStatus <= '0;
    end else if (strobe.takeExc) begin
      stateWord   <= entryState;
      savedPc     <= instAddr;
      savedStatus <= syndrome;
    end else if (strobe.doRfi) begin
      stateWord   <= rfiState;
    end else if (strobe.doWrite) begin
      stateWord   <= stateWrData;
    end
  end

  AST_ME_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeExc |=> !stateWord[POS_ME]); // R3
  AST_LE_FROM_ILE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeExc |=> stateWord[POS_LE] == $past(stateWord[POS_ILE])); // R3
  AST_INHERIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeExc |=> savedStatus[16:31] == $past(stateWord[16:31])); // R6
  AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeExc |=> ($stable(savedStatus) && $stable(savedPc))); // R12
endmodule

// File: rtl/mchk_capture_unit.sv
module mchk_capture_unit
  import mck_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkEnable,
  input  logic [ARR_N-1:0]  errArray,
  input  logic [BUS_N-1:0]  errBus,
  input  logic              selfTestDone,
  input  logic [ARR_N-1:0]  selfTestFail,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              rfiReq,
  input  logic              stateWrEn,
  input  logic [0:31]       stateWrData,
  input  logic              retireReq,
  output logic [0:31]       stateWord,
  output logic [ADDR_W-1:0] savedPc,
  output logic [0:31]       savedStatus,
  output logic              vectorTaken,
  output logic              checkstop,
  output logic              retireGrant
);
  mckStrobe_t       strobe;
  logic [ARR_N-1:0] arrayCause;
  logic             meBit;

  mck_control i_ctrl (
    .clk(clk), .rstN(rstN), .chkEnable(chkEnable), .errArray(errArray),
    .errBus(errBus), .selfTestDone(selfTestDone), .selfTestFail(selfTestFail),
    .meBit(meBit), .rfiReq(rfiReq), .stateWrEn(stateWrEn), .retireReq(retireReq),
    .strobe(strobe), .arrayCause(arrayCause), .checkstop(checkstop),
    .vectorTaken(vectorTaken), .retireGrant(retireGrant)
  );

  mck_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .arrayCause(arrayCause),
    .errBus(errBus), .instAddr(instAddr), .stateWrData(stateWrData),
    .stateWord(stateWord), .savedPc(savedPc), .savedStatus(savedStatus),
    .meBit(meBit)
  );
endmodule

// File: tb/test_mchk_capture_unit.sv
module test_mchk_capture_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        chkEnable = 0;
  logic [4:0]  errArray = '0;
  logic [5:0]  errBus = '0;
  logic        selfTestDone = 0;
  logic [4:0]  selfTestFail = '0;
  logic [31:0] instAddr = '0;
  logic        rfiReq = 0;
  logic        stateWrEn = 0;
  logic [0:31] stateWrData = '0;
  logic        retireReq = 1;
  logic [0:31] stateWord;
  logic [31:0] savedPc;
  logic [0:31] savedStatus;
  logic        vectorTaken, checkstop, retireGrant;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mchk_capture_unit i_mchk_capture_unit (
    .clk(clk), .rstN(rstN), .chkEnable(chkEnable), .errArray(errArray),
    .errBus(errBus), .selfTestDone(selfTestDone), .selfTestFail(selfTestFail),
    .instAddr(instAddr), .rfiReq(rfiReq), .stateWrEn(stateWrEn),
    .stateWrData(stateWrData), .retireReq(retireReq), .stateWord(stateWord),
    .savedPc(savedPc), .savedStatus(savedStatus), .vectorTaken(vectorTaken),
    .checkstop(checkstop), .retireGrant(retireGrant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [0:31] expSyn(input logic [0:31] s, input logic [4:0] a, input logic [5:0] b);
    logic [0:31] r = '0;
    for (int i = 0; i < 5; i++) r[1 + i] = a[i];
    for (int j = 0; j < 6; j++) r[10 + j] = b[j];
    r[16:31] = s[16:31];
    return r;
  endfunction

  function automatic logic [0:31] expEntry(input logic [0:31] s);
    logic [0:31] r = '0;
    r[15] = s[15]; r[25] = s[25]; r[31] = s[15];
    return r;
  endfunction

  task automatic doReset(input logic ce);
    @(negedge clk); rstN = 0; chkEnable = ce;
    @(negedge clk); @(negedge clk); rstN = 1; chkEnable = 0;
  endtask

  task automatic writeState(input logic [0:31] v);
    stateWrEn = 1; stateWrData = v;
    @(negedge clk); stateWrEn = 0;
  endtask

  task automatic doRfi();
    rfiReq = 1; @(negedge clk); rfiReq = 0;
  endtask

  // Fire errors from an enabled state and check the full capture.
  task automatic fireAndCheck(input string req, input logic [0:31] s, input logic [4:0] a,
                              input logic [5:0] b, input logic [31:0] addr);
    writeState(s);
    errArray = a; errBus = b; instAddr = addr;
    @(negedge clk);
    errArray = '0; errBus = '0;
    chk({req, " R1 vector"}, vectorTaken, 1);
    chk({req, " R1 no stop"}, checkstop, 0);
    chk({req, " R4 R5 R6 status"}, savedStatus, expSyn(s, a, b));
    chk({req, " R3 entry state"}, stateWord, expEntry(s));
    chk({req, " R7 pc"}, savedPc, addr);
    @(negedge clk);
    chk({req, " R1 pulse ends"}, vectorTaken, 0);
  endtask

  task automatic testReset();
    doReset(0);
    chk("R12 reset state", stateWord, 0);
    chk("R12 reset status", savedStatus, 0);
    chk("R12 reset stop", checkstop, 0);
    chk("R1 reset vector", vectorTaken, 0);
    chk("R13 grant", retireGrant, 1);
  endtask

  task automatic testSingleSources();
    logic [0:31] s = '0;
    s[15] = 1; s[16] = 1; s[17] = 1; s[18] = 1; s[19] = 1; s[25] = 1; s[26] = 1; s[27] = 1; s[30] = 1;
    for (int i = 0; i < 5; i++) fireAndCheck("R4 array", s, 5'(1 << i), '0, 32'h1000 + i);
    s[15] = 0;
    for (int j = 0; j < 6; j++) fireAndCheck("R5 bus", s, '0, 6'(1 << j), 32'h2000 + j);
    fireAndCheck("R8 multi", s, 5'b10101, 6'b100110, 32'hDEAD_BEEC);
  endtask

  task automatic testRfi();
    logic [0:31] s = 32'h0001_9E72;
    s[19] = 1; s[15] = 1;
    fireAndCheck("R10 setup", s, 5'b00010, '0, 32'h40);
    doRfi();
    chk("R10 restore", stateWord, {expEntry(s)[0:15], s[16:31]});
    // Exception and restore in the same cycle: exception wins.
    rfiReq = 1; errBus = 6'b000001;
    @(negedge clk); rfiReq = 0; errBus = '0;
    chk("R10 exc wins vector", vectorTaken, 1);
    chk("R10 exc wins state", stateWord, expEntry({expEntry(s)[0:15], s[16:31]}));
    @(negedge clk);
    // Write and restore together: restore wins.
    stateWrEn = 1; stateWrData = 32'hFFFF_FFFF; rfiReq = 1;
    @(negedge clk); stateWrEn = 0; rfiReq = 0;
    chk("R11 rfi over write", stateWord,
        {expEntry({expEntry(s)[0:15], s[16:31]})[0:15], savedStatus[16:31]});
    writeState(32'h1234_5678);
    chk("R11 write", stateWord, 32'h1234_5678);
  endtask

  task automatic testCheckstop();
    logic [0:31] s = '0;
    logic [0:31] held;
    s[19] = 1;
    fireAndCheck("R2 setup", s, '0, 6'b000100, 32'h80);
    held = savedStatus;
    errArray = 5'b01000; instAddr = 32'h99;
    @(negedge clk); errArray = '0;
    chk("R2 stop after second fault", checkstop, 1);
    chk("R2 no vector", vectorTaken, 0);
    chk("R13 grant blocked", retireGrant, 0);
    writeState(s);
    errBus = 6'b111111;
    @(negedge clk); @(negedge clk); errBus = '0;
    chk("R12 status held", savedStatus, held);
    chk("R12 pc held", savedPc, 32'h80);
    chk("R12 sticky", checkstop, 1);
    chk("R1 no vector in stop", vectorTaken, 0);
    doReset(0);
    chk("R12 reset clears stop", checkstop, 0);
    errBus = 6'b010000;
    @(negedge clk); errBus = '0;
    chk("R2 disabled at reset", checkstop, 1);
    chk("R2 no vector", vectorTaken, 0);
  endtask

  task automatic testSelfTest();
    logic [0:31] s = '0;
    s[19] = 1;
    doReset(1);
    writeState(s);
    selfTestDone = 1; selfTestFail = 5'b10010;
    @(negedge clk); selfTestDone = 0; selfTestFail = '0;
    chk("R9 armed vector", vectorTaken, 1);
    chk("R9 armed status", savedStatus, expSyn(s, 5'b10010, '0));
    writeState(s);
    selfTestDone = 1; selfTestFail = 5'b00001;
    @(negedge clk); selfTestDone = 0; selfTestFail = '0;
    chk("R9 disarmed after use", vectorTaken, 0);
    doReset(0);
    writeState(s);
    selfTestDone = 1; selfTestFail = 5'b11111;
    @(negedge clk); selfTestDone = 0; selfTestFail = '0;
    chk("R9 unarmed vector", vectorTaken, 0);
    chk("R9 unarmed status", savedStatus, 0);
    chk("R9 unarmed state", stateWord, s);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testSingleSources();
    testRfi();
    testCheckstop();
    testSelfTest();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule